// File: doc/BRIEF.md
# Data-Strobe Serial Transmitter

This block turns a parallel nibble from the link side into a serial data/strobe pair for one cable port. A word is captured on every rising edge of the system clock. The word is then shifted out, least significant lane first, in a fast bit-clock domain that runs at four times the system clock. Each serial bit goes out on the data line. The strobe line toggles on any bit period in which the data line does not change, so the exclusive-or of the two lines flips once per bit.

A speed select picks one of two modes. The low-speed mode consumes two lanes per system cycle at twice the system rate. The high-speed mode consumes all four lanes at four times the system rate. A 2-bit phase counter in the fast domain locks to the arrival of each captured word and gives the clock enable for both rates, so one fast clock serves both modes. A drive-enable output is high only while bits are being sent. When transmit is off, both lines are held low, which also clears the encoder history before the next burst.

Top module: `ds_tx_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), `tpb_data`, `tpa_strobe` and `tx_drive` are 0 from the first fast-clock edge of reset. This holds even if `tx_en` is 1.
- R2: A word captured with `tx_en`=0 produces `tpb_data`=0, `tpa_strobe`=0 and `tx_drive`=0 for its whole slot, whatever its data.
- R3: With `tx_spd`=1 (high speed), the four lanes of a captured word are sent in the order bit 0, 1, 2, 3. Each bit lasts one fast-clock period.
- R4: With `tx_spd`=0 (low speed), only bits 0 and 1 are sent, in that order, and each lasts two fast-clock periods. Bits 2 and 3 have no effect on the outputs.
- R5: While sending, `tpa_strobe` toggles exactly when the new data bit equals the previous one. As a result, `tpb_data` XOR `tpa_strobe` changes on every bit period.
- R6: Each burst starts from a data/strobe history of zero, so its first bit appears with `tpa_strobe` = NOT `tpb_data`.
- R7: Bit 0 of a word captured at system edge T appears on the outputs at the fast-clock edge two fast periods after T. `tx_drive` rises together with that bit.
- R8: The speed mode may change between consecutive enabled words. The stream stays gap-free, and each word is sent in its own mode.
- R9: `tx_drive` stays high for exactly four fast-clock periods per enabled word in either mode, and falls right after the last bit of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; parallel inputs are captured on its rising edge |
| bit_clk | input | 1 | Fast serial clock, four times `sys_clk`, rising edges aligned |
| rst | input | 1 | Synchronous active-high reset for both domains |
| tx_data | input | 4 | Parallel lanes, bit 0 sent first |
| tx_spd | input | 1 | Speed mode: 0 = two lanes per cycle, 1 = four lanes per cycle |
| tx_en | input | 1 | Transmit enable, captured with the data |
| tpb_data | output | 1 | Serial data line |
| tpa_strobe | output | 1 | Serial strobe line |
| tx_drive | output | 1 | Drive-enable for the transmit pairs |

## Verification
A word driven before system edge T first reaches the outputs at the fast edge at T+2 fast periods. That is one register stage to capture the word in the system domain, one to load it into the fast domain, and one for the output register. After that, a new bit follows every one or two fast periods, depending on the mode. The bench samples the outputs at every falling fast edge and records the time of the first drive-enable sample. It compares that time against T plus two and a half fast periods. It compares the captured stream, sample by sample, against a stream it builds from the words and modes it drove, with each low-speed bit repeated twice. Idle periods before and after each burst are checked for low lines, and separate reset checks are sampled half a fast period after the first reset edge.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;
  localparam int DS_LANES = 4;

  typedef enum logic {
    SPD_LOW  = 1'b0,
    SPD_HIGH = 1'b1
  } spd_e;
endpackage

// File: rtl/ds_tx_latch.sv
module ds_tx_latch #(
  parameter int LANES = ds_tx_pkg::DS_LANES
) (
  input  logic             sys_clk,
  input  logic             rst,
  input  logic [LANES-1:0] din,
  input  logic             spd,
  input  logic             en,
  output logic [LANES-1:0] lat_data,
  output logic             lat_spd,
  output logic             lat_en,
  output logic             lat_tgl
);
  always_ff @(posedge sys_clk) begin
    if (rst) begin
      lat_data <= '0;
      lat_spd  <= 1'b0;
      lat_en   <= 1'b0;
      lat_tgl  <= 1'b0;
    end else begin
      lat_data <= din;
      lat_spd  <= spd;
      lat_en   <= en;
      lat_tgl  <= ~lat_tgl;
    end
  end
endmodule

// File: rtl/ds_tx_phase.sv
module ds_tx_phase #(
  parameter int LANES = ds_tx_pkg::DS_LANES,
  localparam int SW = $clog2(LANES)
) (
  input  logic          bit_clk,
  input  logic          rst,
  input  logic          lat_tgl,
  output logic          load,
  output logic [SW-1:0] slot
);
  logic tgl_q;

  assign load = lat_tgl ^ tgl_q;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      tgl_q <= 1'b0;
      slot  <= '0;
    end else begin
      tgl_q <= lat_tgl;
      if (load) slot <= '0;
      else      slot <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/ds_tx_select.sv
module ds_tx_select #(
  parameter int LANES = ds_tx_pkg::DS_LANES,
  localparam int SW = $clog2(LANES)
) (
  input  logic             bit_clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LANES-1:0] lat_data,
  input  logic             lat_spd,
  input  logic             lat_en,
  input  logic [SW-1:0]    slot,
  output logic             ce,
  output logic             en_w,
  output logic             bit_val
);
  import ds_tx_pkg::*;

  logic [LANES-1:0] w_data;
  spd_e             w_spd;
  logic             w_en;
  logic [SW-1:0]    idx;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      w_data <= '0;
      w_spd  <= SPD_LOW;
      w_en   <= 1'b0;
    end else if (load) begin
      w_data <= lat_data;
      w_spd  <= spd_e'(lat_spd);
      w_en   <= lat_en;
    end
  end

  always_comb begin
    if (w_spd == SPD_HIGH) begin
      idx = slot;
      ce  = 1'b1;
    end else begin
      idx = slot >> 1;
      ce  = ~slot[0];
    end
    bit_val = w_data[idx];
    en_w    = w_en;
  end
endmodule

// File: rtl/ds_tx_encode.sv
module ds_tx_encode (
  input  logic bit_clk,
  input  logic rst,
  input  logic ce,
  input  logic en_w,
  input  logic bit_val,
  output logic d_o,
  output logic s_o,
  output logic oe_o
);
  always_ff @(posedge bit_clk) begin
    if (rst) begin
      d_o  <= 1'b0;
      s_o  <= 1'b0;
      oe_o <= 1'b0;
    end else if (ce) begin
      if (en_w) begin
        d_o  <= bit_val;
        s_o  <= (bit_val == d_o) ? ~s_o : s_o;
        oe_o <= 1'b1;
      end else begin
        d_o  <= 1'b0;
        s_o  <= 1'b0;
        oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ds_tx_top.sv
module ds_tx_top #(
  parameter int LANES = ds_tx_pkg::DS_LANES,
  localparam int SW = $clog2(LANES)
) (
  input  logic             sys_clk,
  input  logic             bit_clk,
  input  logic             rst,
  input  logic [LANES-1:0] tx_data,
  input  logic             tx_spd,
  input  logic             tx_en,
  output logic             tpb_data,
  output logic             tpa_strobe,
  output logic             tx_drive
);
  logic [LANES-1:0] lat_data;
  logic             lat_spd, lat_en, lat_tgl;
  logic             load;
  logic [SW-1:0]    slot;
  logic             sel_ce, sel_en, sel_bit;

  ds_tx_latch #(.LANES(LANES)) u_latch (
    .sys_clk(sys_clk), .rst(rst), .din(tx_data), .spd(tx_spd), .en(tx_en),
    .lat_data(lat_data), .lat_spd(lat_spd), .lat_en(lat_en), .lat_tgl(lat_tgl)
  );

  ds_tx_phase #(.LANES(LANES)) u_phase (
    .bit_clk(bit_clk), .rst(rst), .lat_tgl(lat_tgl), .load(load), .slot(slot)
  );

  ds_tx_select #(.LANES(LANES)) u_sel (
    .bit_clk(bit_clk), .rst(rst), .load(load), .lat_data(lat_data),
    .lat_spd(lat_spd), .lat_en(lat_en), .slot(slot),
    .ce(sel_ce), .en_w(sel_en), .bit_val(sel_bit)
  );

  ds_tx_encode u_enc (
    .bit_clk(bit_clk), .rst(rst), .ce(sel_ce), .en_w(sel_en), .bit_val(sel_bit),
    .d_o(tpb_data), .s_o(tpa_strobe), .oe_o(tx_drive)
  );
endmodule

// File: rtl/ds_tx_chk.sv
module ds_tx_chk (
  input logic bit_clk,
  input logic rst,
  input logic ce,
  input logic en_w,
  input logic d,
  input logic s,
  input logic oe
);
  p_idle_low_r2: assert property (@(posedge bit_clk) disable iff (rst)
    !oe |-> (!d && !s));

  p_xor_flip_r5: assert property (@(posedge bit_clk) disable iff (rst)
    (ce && en_w && oe) |=> ((d ^ s) != $past(d ^ s)));

  p_hold_r4: assert property (@(posedge bit_clk) disable iff (rst)
    !ce |=> $stable({d, s, oe}));

  p_first_strobe_r6: assert property (@(posedge bit_clk) disable iff (rst)
    $rose(oe) |-> (s == !d));

  p_drive_on_r7: assert property (@(posedge bit_clk) disable iff (rst)
    (ce && en_w) |=> oe);
endmodule

bind ds_tx_top ds_tx_chk u_chk (
  .bit_clk(bit_clk), .rst(rst), .ce(sel_ce), .en_w(sel_en),
  .d(tpb_data), .s(tpa_strobe), .oe(tx_drive)
);

// File: tb/ds_tx_top_tb_top.sv
module ds_tx_top_tb_top;
  logic sys_clk, bit_clk, rst;
  logic [3:0] tx_data;
  logic tx_spd, tx_en;
  logic tpb_data, tpa_strobe, tx_drive;

  int checks = 0;
  int errors = 0;
  int ph = 0;

  logic [3:0] wd [0:127];
  logic       wm [0:127];
  logic cap_d [0:4095];
  logic cap_s [0:4095];
  logic cap_o [0:4095];
  logic exp_d [0:4095];
  logic exp_s [0:4095];
  int   ncap;
  logic col_on = 1'b0;
  logic seen;
  time  t_oe, t_lat;

  ds_tx_top dut_i (
    .sys_clk(sys_clk), .bit_clk(bit_clk), .rst(rst), .tx_data(tx_data),
    .tx_spd(tx_spd), .tx_en(tx_en), .tpb_data(tpb_data),
    .tpa_strobe(tpa_strobe), .tx_drive(tx_drive)
  );

  initial begin
    bit_clk = 1'b0;
    sys_clk = 1'b0;
    forever begin
      bit_clk = 1'b1;
      if (ph == 0) sys_clk = 1'b1;
      else if (ph == 2) sys_clk = 1'b0;
      #2;
      bit_clk = 1'b0;
      #2;
      ph = (ph + 1) % 4;
    end
  end

  always @(negedge bit_clk) begin
    if (col_on && ncap < 4096) begin
      cap_d[ncap] = tpb_data;
      cap_s[ncap] = tpa_strobe;
      cap_o[ncap] = tx_drive;
      ncap = ncap + 1;
      if (tx_drive && !seen) begin
        seen = 1'b1;
        t_oe = $time;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input int n, input string req);
    int L, k, f, bad_d, bad_s, bad_o, bad_idle;
    logic pd, ps;
    pd = 1'b0; ps = 1'b0; L = 0;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < (wm[i] ? 4 : 2); b++) begin
        logic nd, ns;
        nd = wd[i][b];
        ns = (nd == pd) ? ~ps : ps;
        for (int r = 0; r < (wm[i] ? 1 : 2); r++) begin
          exp_d[L] = nd; exp_s[L] = ns; L++;
        end
        pd = nd; ps = ns;
      end
    end
    ncap = 0; seen = 1'b0;
    col_on = 1'b1;
    repeat (2) begin
      @(negedge sys_clk);
      tx_en = 1'b0; tx_data = $urandom; tx_spd = $urandom;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge sys_clk);
      tx_en = 1'b1; tx_data = wd[i]; tx_spd = wm[i];
      if (i == 0) t_lat = $time + 8;
    end
    repeat (4) begin
      @(negedge sys_clk);
      tx_en = 1'b0; tx_data = $urandom; tx_spd = $urandom;
    end
    @(negedge sys_clk);
    col_on = 1'b0;
    f = -1;
    for (int i = 0; i < ncap; i++) if (f < 0 && cap_o[i]) f = i;
    chk(f >= 0, req, "burst produced no drive", f, 0);
    if (f < 0) return;
    chk(t_oe == t_lat + 10, "R7", "first bit time offset ns", t_oe - t_lat, 10);
    bad_d = 0; bad_s = 0; bad_o = 0; bad_idle = 0;
    for (int i = 0; i < L; i++) begin
      k = f + i;
      if (cap_o[k] !== 1'b1) bad_o++;
      if (cap_d[k] !== exp_d[i]) bad_d++;
      if (cap_s[k] !== exp_s[i]) bad_s++;
    end
    for (int i = f + L; i < ncap; i++) if (cap_o[i] !== 1'b0) bad_o++;
    for (int i = 0; i < ncap; i++)
      if ((i < f || i >= f + L) && (cap_d[i] !== 1'b0 || cap_s[i] !== 1'b0)) bad_idle++;
    chk(bad_o == 0, "R9", "drive length mismatches", bad_o, 0);
    chk(bad_d == 0, req, "data bit mismatches", bad_d, 0);
    chk(bad_s == 0, "R5", "strobe mismatches", bad_s, 0);
    chk(cap_s[f] == !cap_d[f], "R6", "first strobe", cap_s[f], !cap_d[f]);
    chk(bad_idle == 0, "R2", "idle non-low samples", bad_idle, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; tx_en = 1'b1; tx_spd = 1'b1; tx_data = 4'hF;
    repeat (4) @(negedge sys_clk);
    chk({tpb_data, tpa_strobe, tx_drive} == 3'b000, "R1", "outputs in reset",
        {tpb_data, tpa_strobe, tx_drive}, 0);
    tx_en = 1'b0;
    @(negedge sys_clk);
    rst = 1'b0;
    repeat (3) @(negedge sys_clk);
    chk({tpb_data, tpa_strobe, tx_drive} == 3'b000, "R2", "outputs while disabled",
        {tpb_data, tpa_strobe, tx_drive}, 0);

    // R3: high speed, every nibble value
    for (int i = 0; i < 16; i++) begin wd[i] = i[3:0]; wm[i] = 1'b1; end
    run_burst(16, "R3");

    // R4: low speed, every value of the used lanes, junk in upper lanes
    for (int i = 0; i < 16; i++) begin wd[i] = i[3:0]; wm[i] = 1'b0; end
    run_burst(16, "R4");

    // R8: random modes switching word by word
    for (int i = 0; i < 64; i++) begin wd[i] = $urandom; wm[i] = $urandom; end
    run_burst(64, "R8");

    // R6: single-word bursts over every value and both modes
    for (int v = 0; v < 16; v++)
      for (int m = 0; m < 2; m++) begin
        wd[0] = v[3:0]; wm[0] = m[0];
        run_burst(1, "R6");
      end

    // R1: reset in the middle of a burst
    @(negedge sys_clk);
    tx_en = 1'b1; tx_spd = 1'b1; tx_data = 4'hA;
    repeat (3) @(negedge sys_clk);
    chk(tx_drive == 1'b1, "R7", "drive during stream", tx_drive, 1);
    @(negedge bit_clk);
    rst = 1'b1;
    @(negedge bit_clk);
    chk({tpb_data, tpa_strobe, tx_drive} == 3'b000, "R1", "outputs after mid-burst reset",
        {tpb_data, tpa_strobe, tx_drive}, 0);
    repeat (3) @(negedge sys_clk);
    tx_en = 1'b0;
    rst = 1'b0;
    wd[0] = 4'b0110; wm[0] = 1'b1;
    run_burst(1, "R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule